// File: doc/BRIEF.md
# Sequential Booth Multiplier with Operand-Dependent Latency

This unit multiplies two 16-bit operands over many clock cycles. A caller pulses a start input while the unit is idle, together with a mode bit and two operands: a multiplicand and a source. The unit runs radix-2 Booth steps on the source. The operand bits and the mode set how many cycles the run takes. The product appears on a 32-bit output and stays there until the next accepted start.

Run time is not fixed. It is a base of 38 cycles plus two cycles for each counted feature of the source. In unsigned mode, the features are the source's set bits. In signed mode, a zero is placed below the source's least significant bit, and the features are the neighbouring bit pairs of that 17-bit word whose two bits differ. This lets a cycle-accurate model of an older processor stall for exactly as long as that processor's multiply took. A cycle counter output reports the length of the run.

Top module: `mulseq_top`

## Requirements
- R1: With mode bit 0 (unsigned), the product output at the done pulse equals the unsigned 32-bit product of the two operands.
- R2: With mode bit 1 (signed), the product output at the done pulse equals the two's-complement 32-bit product of the two operands, each read as signed 16-bit.
- R3: In unsigned mode, the run lasts 38 plus twice the number of set bits in the source, counted in clock cycles.
- R4: In signed mode, the run lasts 38 plus twice the number of differing adjacent pairs in the 17-bit word formed by the source followed by a zero.
- R5: Busy rises on the edge that accepts start. It stays high for exactly the run length and includes the done cycle.
- R6: Done is high for one cycle only, in the last busy cycle. At that point the cycle count output equals the run length.
- R7: A start pulse while busy is ignored. The current run's length and product are unchanged.
- R8: After done, the product and cycle count hold their values until the next accepted start. Operand inputs may change after start is accepted without affecting the result.
- R9: Synchronous active-high reset forces busy, done, product and cycle count to zero, even in the middle of a run.
- R10: Corner cases: an unsigned source of 0x0000 takes 38 cycles and gives product 0. An unsigned source of 0xFFFF and a signed source of 0x5555 each take the longest run, 70 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| signed_i | input | 1 | 0 = unsigned, 1 = signed |
| mcand_i | input | 16 | Multiplicand operand |
| src_i | input | 16 | Source operand; its bits set the run time |
| product_o | output | 32 | Product, valid from done until next start |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse in the final run cycle |
| cycles_o | output | 7 | Cycles used by the current or last run |

## Verification
The assertions assume two things. Reset is applied before the first run. Start is a plain level that is sampled only at clock edges, so a start held high after a run ends begins a new run at once. The bench always drops start one cycle after raising it, except where it raises start on purpose during a busy run. Operands come from a seeded random generator in both modes, mixed with directed sources for the fastest and slowest runs. Operand inputs are scrambled right after each accepted start, which shows that the values are captured at start.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    localparam int OPW_DEF  = 16;
    localparam int BASE_DEF = 38;

    typedef enum logic {
        MODE_UNS = 1'b0,
        MODE_SGN = 1'b1
    } mul_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_e;

    function automatic int max_latency(input int w, input int base);
        return base + 2 * w;
    endfunction

endpackage

// File: rtl/mulseq_lat.sv
module mulseq_lat
    import mulseq_pkg::*;
#(
    parameter int W    = OPW_DEF,
    parameter int BASE = BASE_DEF,
    parameter int CW   = $clog2(max_latency(OPW_DEF, BASE_DEF) + 1)
) (
    input  mul_mode_e        mode,
    input  logic [W-1:0]     src,
    output logic [CW-1:0]    lat
);

    logic [W:0] ext;
    int         feat;

    assign ext = {src, 1'b0};

    always_comb begin
        feat = 0;
        for (int i = 0; i < W; i++) begin
            if (mode == MODE_UNS) begin
                feat = feat + int'(src[i]);
            end else begin
                feat = feat + int'(ext[i+1] ^ ext[i]);
            end
        end
        lat = CW'(BASE + 2 * feat);
    end

endmodule

// File: rtl/mulseq_dp.sv
module mulseq_dp
    import mulseq_pkg::*;
#(
    parameter int W = OPW_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  mul_mode_e      mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   src,
    output logic [2*W-1:0] product
);

    localparam int AW = W + 2;
    localparam int QW = W + 1;
    localparam int SW = $clog2(QW + 1);

    logic [AW-1:0] acc, m_reg, sum;
    logic [QW-1:0] q;
    logic          qm1;
    logic [SW-1:0] step;
    logic          run;
    logic [AW+QW-1:0] full;

    always_comb begin
        unique case ({q[0], qm1})
            2'b01:   sum = acc + m_reg;
            2'b10:   sum = acc - m_reg;
            default: sum = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            m_reg <= '0;
            q     <= '0;
            qm1   <= 1'b0;
            step  <= '0;
            run   <= 1'b0;
        end else if (load) begin
            acc   <= '0;
            m_reg <= (mode == MODE_SGN) ? {{2{mcand[W-1]}}, mcand} : {2'b00, mcand};
            q     <= (mode == MODE_SGN) ? {src[W-1], src} : {1'b0, src};
            qm1   <= 1'b0;
            step  <= '0;
            run   <= 1'b1;
        end else if (run) begin
            acc  <= {sum[AW-1], sum[AW-1:1]};
            q    <= {sum[0], q[QW-1:1]};
            qm1  <= q[0];
            step <= step + SW'(1);
            if (step == SW'(QW - 1)) begin
                run <= 1'b0;
            end
        end
    end

    assign full    = {acc, q};
    assign product = full[2*W-1:0];

    p_step_range_r1: assert property (@(posedge clk) disable iff (rst)
        run |-> (step < SW'(QW)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(acc) && $stable(q));

endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
    import mulseq_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] lat,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] elapsed
);

    ctrl_state_e   state;
    logic [CW-1:0] target;

    assign accept = start && (state == ST_IDLE);
    assign busy   = (state == ST_RUN);
    assign done   = busy && (elapsed == target);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            elapsed <= '0;
            target  <= '0;
        end else if (accept) begin
            state   <= ST_RUN;
            elapsed <= CW'(1);
            target  <= lat;
        end else if (state == ST_RUN) begin
            if (elapsed == target) begin
                state <= ST_IDLE;
            end else begin
                elapsed <= elapsed + CW'(1);
            end
        end
    end

    p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy && $stable(target));

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy && (elapsed == $past(elapsed) + CW'(1)));

endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
    import mulseq_pkg::*;
#(
    parameter int W    = OPW_DEF,
    parameter int BASE = BASE_DEF,
    parameter int CW   = $clog2(max_latency(OPW_DEF, BASE_DEF) + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   src_i,
    output logic [2*W-1:0] product_o,
    output logic           busy_o,
    output logic           done_o,
    output logic [CW-1:0]  cycles_o
);

    localparam int MAXLAT = max_latency(W, BASE);

    mul_mode_e     mode;
    logic [CW-1:0] lat;
    logic          accept;

    assign mode = signed_i ? MODE_SGN : MODE_UNS;

    mulseq_lat #(.W(W), .BASE(BASE), .CW(CW)) u_lat (
        .mode (mode),
        .src  (src_i),
        .lat  (lat)
    );

    mulseq_ctrl #(.CW(CW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start_i),
        .lat     (lat),
        .accept  (accept),
        .busy    (busy_o),
        .done    (done_o),
        .elapsed (cycles_o)
    );

    mulseq_dp #(.W(W)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .mode    (mode),
        .mcand   (mcand_i),
        .src     (src_i),
        .product (product_o)
    );

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    p_done_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    p_lat_window_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cycles_o >= CW'(BASE)) && (cycles_o <= CW'(MAXLAT)));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(product_o) && $stable(cycles_o));

    p_start_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o && (cycles_o == CW'(1)));

endmodule

// File: tb/test_mulseq_top.sv
module test_mulseq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        signed_i = 1'b0;
    logic [15:0] mcand_i = '0;
    logic [15:0] src_i = '0;
    logic [31:0] product_o;
    logic        busy_o;
    logic        done_o;
    logic [6:0]  cycles_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mulseq_top i_mulseq_top (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .signed_i  (signed_i),
        .mcand_i   (mcand_i),
        .src_i     (src_i),
        .product_o (product_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .cycles_o  (cycles_o)
    );

    function automatic int exp_lat(input bit sm, input logic [15:0] s);
        logic [16:0] e;
        int c;
        c = 0;
        e = {s, 1'b0};
        for (int i = 0; i < 16; i++) begin
            if (!sm) c += int'(s[i]);
            else     c += int'(e[i+1] ^ e[i]);
        end
        return 38 + 2 * c;
    endfunction

    function automatic logic [31:0] exp_prod(input bit sm, input logic [15:0] a, input logic [15:0] b);
        logic signed [31:0] sa, sb;
        if (sm) begin
            sa = {{16{a[15]}}, a};
            sb = {{16{b[15]}}, b};
            return sa * sb;
        end
        return {16'h0, a} * {16'h0, b};
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit sm, input logic [15:0] a, input logic [15:0] b, input bit poke);
        int k;
        int L;
        logic [31:0] p;
        logic [31:0] held;
        L = exp_lat(sm, b);
        p = exp_prod(sm, a, b);
        @(negedge clk);
        start_i = 1'b1; signed_i = sm; mcand_i = a; src_i = b;
        @(negedge clk);
        start_i = 1'b0;
        mcand_i = ~a; src_i = b ^ 16'h3C5A; signed_i = ~sm;
        check(busy_o == 1'b1, "R5 busy after start", busy_o, 1);
        k = 1;
        while (!done_o && k < 100) begin
            if (poke && k == 10) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            if (!busy_o) begin
                check(0, "R5 busy dropped early", k, L);
                break;
            end
            k++;
        end
        if (sm) check(k == L, "R4 signed latency", k, L);
        else    check(k == L, "R3 unsigned latency", k, L);
        check(cycles_o == 7'(L), "R6 cycle count at done", cycles_o, L);
        if (sm) check(product_o == p, "R2 signed product", product_o, p);
        else    check(product_o == p, "R1 unsigned product", product_o, p);
        if (poke) check(product_o == p && k == L, "R7 start while busy ignored", product_o, p);
        held = product_o;
        @(negedge clk);
        check(!done_o && !busy_o, "R6 done single pulse", {done_o, busy_o}, 0);
        repeat (3) @(negedge clk);
        check(product_o == held && cycles_o == 7'(L), "R8 result held", product_o, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && product_o == 0 && cycles_o == 0, "R9 reset state", {busy_o, done_o, cycles_o}, 0);

        // R10 directed corners
        run_op(1'b0, 16'h1234, 16'h0000, 1'b0);
        check(product_o == 0 && cycles_o == 7'd38, "R10 zero source minimum", cycles_o, 38);
        run_op(1'b0, 16'hFFFF, 16'hFFFF, 1'b0);
        check(cycles_o == 7'd70, "R10 unsigned worst", cycles_o, 70);
        run_op(1'b1, 16'h8000, 16'h5555, 1'b0);
        check(cycles_o == 7'd70, "R10 signed worst", cycles_o, 70);
        run_op(1'b1, 16'h8000, 16'h8000, 1'b0);
        run_op(1'b1, 16'hFFFF, 16'h7FFF, 1'b0);
        run_op(1'b1, 16'h0000, 16'hFFFF, 1'b0);

        // R7 start during run
        run_op(1'b0, 16'hABCD, 16'h0F0F, 1'b1);
        run_op(1'b1, 16'h9876, 16'hAAAA, 1'b1);

        for (int i = 0; i < 60; i++) begin
            run_op(1'($urandom), 16'($urandom), 16'($urandom), 1'b0);
        end

        // R9 reset mid-run
        @(negedge clk);
        start_i = 1'b1; signed_i = 1'b0; mcand_i = 16'h00FF; src_i = 16'h00FF;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && product_o == 0 && cycles_o == 0, "R9 reset mid-run", {busy_o, done_o, cycles_o}, 0);
        rst = 1'b0;
        run_op(1'b1, 16'h7FFF, 16'h8001, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule